// File: doc/BRIEF.md
# Endpoint Test-Function Command Engine

This block is the register front end and command sequencer of a bus endpoint used as a test target. A host programs a pattern register, source and destination buffer addresses, a byte count and a checksum through a small word-addressed register port. It then writes a command word. The command word selects one transfer operation and may also request an interrupt. The three operations are: fetch a host buffer and verify its checksum, fill a host buffer with a known pattern, and copy one host buffer to another.

Transfers use a word-wide memory master port. On that port, a request is held until it is acknowledged, and an error flag comes back with the acknowledge. When the command finishes, the engine posts the outcome in a status register and clears the command register. If an interrupt was requested, the engine also raises a one-cycle legacy interrupt pulse, a one-cycle numbered message interrupt pulse, or both.

Top module: `ep_test_engine`

## Requirements
- R1: Registers sit at word addresses 0 pattern, 1 command, 2 status, 3 source address, 4 destination address, 5 byte count, 6 checksum. All reset to zero. The pattern register reads back exactly what was written. Host writes to the status register are ignored.
- R2: A command is accepted when the host writes a value with any of bits 10:0 set while the engine is idle. Accepting a command clears the status register. The command register reads back the command until the operation completes, and then reads zero.
- R3: Fetch (command bit 8) reads ceil(count/4) words from the source address, rising by 4 per word, and sums them modulo 2^32. It sets status bit 0 when the sum equals the checksum register and status bit 1 otherwise. A count of zero gives a sum of zero.
- R4: Write (command bit 9) writes ceil(count/4) whole words to the destination address. Word i holds the bytes 4i, 4i+1, 4i+2, 4i+3 (each modulo 256), least significant byte first. On success the engine stores the modulo-2^32 sum of those words in the checksum register and sets status bit 2.
- R5: Copy (command bit 10) moves ceil(count/4) words from the source buffer to the destination buffer in order, one read then one write per word, and sets status bit 4.
- R6: An address is invalid when it is zero or has nonzero low two bits. An invalid source sets status bit 7, and an invalid destination sets status bit 8. Either one sets the fail bit of the operation (1 fetch, 3 write, 5 copy), and the operation makes no memory request.
- R7: An error flag on any acknowledged beat ends the operation at once with its fail bit set (1, 3 or 5). A failed write leaves the checksum register unchanged.
- R8: When a command completes, bit 0 gives a one-cycle pulse on irq_legacy and bit 1 gives a one-cycle pulse on irq_msg with irq_vec equal to command bits 7:2. Either request sets status bit 6.
- R9: Writes to the command register are ignored while an operation is running.
- R10: When several operation bits are set, fetch takes precedence over write, and write over copy. Only the chosen operation runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory beat acknowledge |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |
| mem_err | input | 1 | Error response, valid with mem_ack |
| irq_legacy | output | 1 | Legacy interrupt pulse |
| irq_msg | output | 1 | Message interrupt pulse |
| irq_vec | output | 6 | Message interrupt number |

## Verification
Fetch is swept over every byte count from 0 to 16, with both a matching and an off-by-one checksum. This separates rounding of partial words, the empty transfer and the compare result. Write and copy run over the same range of counts and check the word past the end of each buffer, which exposes a beat too many or too few. Zero and misaligned addresses, an error response on a chosen beat, all 64 message vectors, a combined command word and a command overwrite during a long fetch test the address checks, the early stop, the interrupt encoding, the priority order and the busy lockout.

// File: rtl/ept_pkg.sv
package ept_pkg;
    typedef enum logic [2:0] {S_IDLE, S_START, S_RD, S_WR, S_DONE} st_e;
    typedef enum logic [1:0] {OP_NONE, OP_FETCH, OP_WRITE, OP_COPY} op_e;

    localparam int RA_MAGIC = 0;
    localparam int RA_CMD   = 1;
    localparam int RA_STAT  = 2;
    localparam int RA_SRC   = 3;
    localparam int RA_DST   = 4;
    localparam int RA_SIZE  = 5;
    localparam int RA_CSUM  = 6;

    localparam int CB_LEG   = 0;
    localparam int CB_MSG   = 1;
    localparam int CB_FETCH = 8;
    localparam int CB_WRITE = 9;
    localparam int CB_COPY  = 10;
    localparam int CMD_W    = 11;

    localparam int SB_F_OK  = 0;
    localparam int SB_F_BAD = 1;
    localparam int SB_W_OK  = 2;
    localparam int SB_W_BAD = 3;
    localparam int SB_C_OK  = 4;
    localparam int SB_C_BAD = 5;
    localparam int SB_IRQ   = 6;
    localparam int SB_SRC   = 7;
    localparam int SB_DST   = 8;
    localparam int STAT_W   = 9;
endpackage

// File: rtl/ept_addr_chk.sv
module ept_addr_chk #(
    parameter int AW    = 32,
    parameter int ALIGN = 2
) (
    input  logic [AW-1:0] addr,
    output logic          bad
);
    assign bad = (addr == '0) || (addr[ALIGN-1:0] != '0);
endmodule

// File: rtl/ept_irq_gen.sv
module ept_irq_gen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  logic       want_leg,
    input  logic       want_msg,
    input  logic [5:0] vec,
    output logic       irq_legacy,
    output logic       irq_msg,
    output logic [5:0] irq_vec
);
    typedef struct packed {
        logic       leg;
        logic       msg;
        logic [5:0] vec;
    } irq_t;

    irq_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.leg = fire && want_leg;
        r_d.msg = fire && want_msg;
        if (fire && want_msg) r_d.vec = vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign irq_legacy = r_q.leg;
    assign irq_msg    = r_q.msg;
    assign irq_vec    = r_q.vec;
endmodule

// File: rtl/ep_test_engine.sv
module ep_test_engine
    import ept_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_err,
    output logic          irq_legacy,
    output logic          irq_msg,
    output logic [5:0]    irq_vec
);
    localparam int BPW   = DW / 8;
    localparam int ALIGN = $clog2(BPW);

    typedef struct packed {
        st_e               st;
        op_e               op;
        logic [DW-1:0]     magic;
        logic [CMD_W-1:0]  cmd;
        logic [STAT_W-1:0] status;
        logic [AW-1:0]     src;
        logic [AW-1:0]     dst;
        logic [DW-1:0]     size;
        logic [DW-1:0]     csum;
        logic [AW-1:0]     rp;
        logic [AW-1:0]     wp;
        logic [DW-1:0]     cnt;
        logic [DW-1:0]     idx;
        logic [DW-1:0]     sum;
        logic [DW-1:0]     hold;
        logic              fail;
    } eng_t;

    eng_t s_d, s_q;
    logic bad_src, bad_dst, fire;
    logic [DW:0]   size_ext;
    logic [DW-1:0] nwords, pat_word;

    ept_addr_chk #(.AW(AW), .ALIGN(ALIGN)) u_chk_src (.addr(s_q.src), .bad(bad_src));
    ept_addr_chk #(.AW(AW), .ALIGN(ALIGN)) u_chk_dst (.addr(s_q.dst), .bad(bad_dst));

    assign size_ext = {1'b0, s_q.size} + (DW+1)'(BPW - 1);
    assign nwords   = DW'(size_ext >> ALIGN);

    always_comb begin
        for (int k = 0; k < BPW; k++)
            pat_word[8*k +: 8] = 8'(s_q.idx * BPW + DW'(k));
    end

    always_comb begin
        s_d       = s_q;
        fire      = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;

        if (reg_we) begin
            case (int'(reg_addr))
                RA_MAGIC: s_d.magic = reg_wdata;
                RA_SRC:   s_d.src   = reg_wdata[AW-1:0];
                RA_DST:   s_d.dst   = reg_wdata[AW-1:0];
                RA_SIZE:  s_d.size  = reg_wdata;
                RA_CSUM:  s_d.csum  = reg_wdata;
                default: ;
            endcase
        end

        case (s_q.st)
            S_IDLE: begin
                if (reg_we && int'(reg_addr) == RA_CMD && reg_wdata[CMD_W-1:0] != '0) begin
                    s_d.cmd    = reg_wdata[CMD_W-1:0];
                    s_d.status = '0;
                    s_d.st     = S_START;
                end
            end
            S_START: begin
                s_d.idx  = '0;
                s_d.sum  = '0;
                s_d.fail = 1'b0;
                s_d.cnt  = nwords;
                s_d.rp   = s_q.src;
                s_d.wp   = s_q.dst;
                s_d.st   = S_DONE;
                if (s_q.cmd[CB_FETCH]) begin
                    s_d.op = OP_FETCH;
                    if (bad_src) begin
                        s_d.status[SB_SRC] = 1'b1;
                        s_d.fail = 1'b1;
                    end else if (nwords != '0) s_d.st = S_RD;
                end else if (s_q.cmd[CB_WRITE]) begin
                    s_d.op = OP_WRITE;
                    if (bad_dst) begin
                        s_d.status[SB_DST] = 1'b1;
                        s_d.fail = 1'b1;
                    end else if (nwords != '0) s_d.st = S_WR;
                end else if (s_q.cmd[CB_COPY]) begin
                    s_d.op = OP_COPY;
                    if (bad_src || bad_dst) begin
                        s_d.status[SB_SRC] = bad_src;
                        s_d.status[SB_DST] = bad_dst;
                        s_d.fail = 1'b1;
                    end else if (nwords != '0) s_d.st = S_RD;
                end else begin
                    s_d.op = OP_NONE;
                end
            end
            S_RD: begin
                mem_req  = 1'b1;
                mem_addr = s_q.rp;
                if (mem_ack) begin
                    if (mem_err) begin
                        s_d.fail = 1'b1;
                        s_d.st   = S_DONE;
                    end else begin
                        s_d.rp = s_q.rp + AW'(BPW);
                        if (s_q.op == OP_FETCH) begin
                            s_d.sum = s_q.sum + mem_rdata;
                            s_d.cnt = s_q.cnt - 1'b1;
                            if (s_q.cnt == DW'(1)) s_d.st = S_DONE;
                        end else begin
                            s_d.hold = mem_rdata;
                            s_d.st   = S_WR;
                        end
                    end
                end
            end
            S_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = s_q.wp;
                mem_wdata = (s_q.op == OP_COPY) ? s_q.hold : pat_word;
                if (mem_ack) begin
                    if (mem_err) begin
                        s_d.fail = 1'b1;
                        s_d.st   = S_DONE;
                    end else begin
                        s_d.sum = s_q.sum + mem_wdata;
                        s_d.wp  = s_q.wp + AW'(BPW);
                        s_d.idx = s_q.idx + 1'b1;
                        s_d.cnt = s_q.cnt - 1'b1;
                        if (s_q.cnt == DW'(1))       s_d.st = S_DONE;
                        else if (s_q.op == OP_COPY)  s_d.st = S_RD;
                    end
                end
            end
            S_DONE: begin
                case (s_q.op)
                    OP_FETCH: begin
                        if (!s_q.fail && s_q.sum == s_q.csum) s_d.status[SB_F_OK] = 1'b1;
                        else                                  s_d.status[SB_F_BAD] = 1'b1;
                    end
                    OP_WRITE: begin
                        if (!s_q.fail) begin
                            s_d.status[SB_W_OK] = 1'b1;
                            s_d.csum = s_q.sum;
                        end else s_d.status[SB_W_BAD] = 1'b1;
                    end
                    OP_COPY: begin
                        if (!s_q.fail) s_d.status[SB_C_OK]  = 1'b1;
                        else           s_d.status[SB_C_BAD] = 1'b1;
                    end
                    default: ;
                endcase
                fire = s_q.cmd[CB_LEG] | s_q.cmd[CB_MSG];
                if (fire) s_d.status[SB_IRQ] = 1'b1;
                s_d.cmd = '0;
                s_d.st  = S_IDLE;
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (int'(reg_addr))
            RA_MAGIC: reg_rdata = s_q.magic;
            RA_CMD:   reg_rdata = DW'(s_q.cmd);
            RA_STAT:  reg_rdata = DW'(s_q.status);
            RA_SRC:   reg_rdata = DW'(s_q.src);
            RA_DST:   reg_rdata = DW'(s_q.dst);
            RA_SIZE:  reg_rdata = s_q.size;
            RA_CSUM:  reg_rdata = s_q.csum;
            default:  reg_rdata = '0;
        endcase
    end

    ept_irq_gen u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .want_leg   (s_q.cmd[CB_LEG]),
        .want_msg   (s_q.cmd[CB_MSG]),
        .vec        (s_q.cmd[7:2]),
        .irq_legacy (irq_legacy),
        .irq_msg    (irq_msg),
        .irq_vec    (irq_vec)
    );
endmodule

// File: rtl/ept_checker.sv
module ept_checker
    import ept_pkg::*;
#(
    parameter int AW    = 32,
    parameter int ALIGN = 2
) (
    input logic              clk,
    input logic              rst_n,
    input st_e               st,
    input logic [CMD_W-1:0]  cmd_q,
    input logic [STAT_W-1:0] status_q,
    input logic              reg_we,
    input logic [2:0]        reg_addr,
    input logic              mem_req,
    input logic [AW-1:0]     mem_addr,
    input logic              irq_legacy,
    input logic              irq_msg
);
    // R8
    leg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_legacy |=> !irq_legacy);
    // R8
    msg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_msg |=> !irq_msg);
    // R8
    irq_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_legacy || irq_msg) |-> status_q[SB_IRQ]);
    // R9
    busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == S_START || st == S_RD || st == S_WR) && reg_we && int'(reg_addr) == RA_CMD)
        |=> $stable(cmd_q));
    // R6
    addr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr != '0 && mem_addr[ALIGN-1:0] == '0));
    // R2
    req_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (st == S_RD || st == S_WR));
    // R3
    one_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({status_q[SB_F_OK], status_q[SB_W_OK], status_q[SB_C_OK]}));
    // R2
    cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DONE) |=> (cmd_q == '0));
endmodule

bind ep_test_engine ept_checker #(.AW(AW), .ALIGN(ALIGN)) u_ept_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (s_q.st),
    .cmd_q      (s_q.cmd),
    .status_q   (s_q.status),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .irq_legacy (irq_legacy),
    .irq_msg    (irq_msg)
);

// File: tb/test_ep_test_engine.sv
`timescale 1ns/1ps
module test_ep_test_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        irq_legacy, irq_msg;
    logic [5:0]  irq_vec;

    int total = 0;
    int bad = 0;
    int leg_cnt = 0, msg_cnt = 0, req_cnt = 0;
    logic [5:0]  seen_vec = '0;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic [31:0] mem [256];

    always #2 clk = ~clk;

    ep_test_engine i_ep_test_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .irq_legacy(irq_legacy), .irq_msg(irq_msg), .irq_vec(irq_vec)
    );

    assign mem_ack   = mem_req;
    assign mem_err   = mem_req && (mem_addr == err_addr);
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (mem_req && mem_we && !mem_err) mem[mem_addr[9:2]] <= mem_wdata;
        if (mem_req) req_cnt <= req_cnt + 1;
        if (irq_legacy) leg_cnt <= leg_cnt + 1;
        if (irq_msg) begin
            msg_cnt  <= msg_cnt + 1;
            seen_vec <= irq_vec;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = 3'(a); #0.5;
        d = reg_rdata;
    endtask

    task automatic run(input logic [31:0] c);
        logic [31:0] v;
        leg_cnt = 0; msg_cnt = 0; req_cnt = 0;
        wr(1, c);
        for (int t = 0; t < 2000; t++) begin
            @(posedge clk); #1;
            rd(1, v);
            if (v == 0) break;
        end
        @(posedge clk); #1;
    endtask

    function automatic logic [31:0] pat(input int i);
        return {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)};
    endfunction

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v, s;
        for (int i = 0; i < 256; i++) mem[i] = 32'(i) * 32'h0103_0507 + 32'h11;
        #9 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        for (int a = 0; a < 7; a++) begin
            rd(a, v);
            check(v == 0, "R1 reset reg", v, 0);
        end
        check(!irq_legacy && !irq_msg, "R8 reset irq", {30'd0, irq_legacy, irq_msg}, 0);

        // R1 pattern register and read-only status
        foreach (v[k]) begin
            wr(0, 32'h1 << k ^ 32'hA5A5_0F0F);
            rd(0, s);
            check(s == (32'h1 << k ^ 32'hA5A5_0F0F), "R1 magic", s, 32'h1 << k ^ 32'hA5A5_0F0F);
        end
        wr(2, 32'h1FF); rd(2, v);
        check(v == 0, "R1 status write ignored", v, 0);

        // R3 fetch sweep
        for (int n = 0; n <= 16; n++) begin
            s = 0;
            for (int i = 0; i < (n + 3) / 4; i++) s += mem[64 + i];
            for (int g = 0; g < 2; g++) begin
                wr(5, n); wr(3, 32'h100); wr(6, g == 0 ? s : s + 1);
                run(32'h100);
                rd(2, v);
                check(v == (g == 0 ? 32'h1 : 32'h2), "R3 fetch status", v, g == 0 ? 1 : 2);
                check(req_cnt == (n + 3) / 4, "R3 fetch beats", req_cnt, (n + 3) / 4);
            end
        end

        // R4 write sweep
        for (int n = 0; n <= 16; n++) begin
            for (int i = 0; i < 6; i++) mem[128 + i] = 32'hDEAD_0000 + i;
            wr(5, n); wr(4, 32'h200);
            run(32'h200);
            s = 0;
            for (int i = 0; i < (n + 3) / 4; i++) begin
                s += pat(i);
                check(mem[128 + i] == pat(i), "R4 write word", mem[128 + i], pat(i));
            end
            check(mem[128 + (n + 3) / 4] == 32'hDEAD_0000 + (n + 3) / 4, "R4 word past end",
                  mem[128 + (n + 3) / 4], 32'hDEAD_0000 + (n + 3) / 4);
            rd(6, v); check(v == s, "R4 checksum", v, s);
            rd(2, v); check(v == 32'h4, "R4 status", v, 4);
        end

        // R5 copy sweep
        for (int n = 0; n <= 16; n++) begin
            for (int i = 0; i < 6; i++) mem[192 + i] = 0;
            wr(5, n); wr(3, 32'h100); wr(4, 32'h300);
            run(32'h400);
            for (int i = 0; i < (n + 3) / 4; i++)
                check(mem[192 + i] == mem[64 + i], "R5 copy word", mem[192 + i], mem[64 + i]);
            check(mem[192 + (n + 3) / 4] == 0, "R5 word past end", mem[192 + (n + 3) / 4], 0);
            rd(2, v); check(v == 32'h10, "R5 status", v, 32'h10);
        end

        // R6 invalid addresses
        wr(5, 8);
        wr(3, 0); run(32'h100); rd(2, v);
        check(v == 32'h82 && req_cnt == 0, "R6 fetch src zero", v, 32'h82);
        wr(3, 32'h102); run(32'h100); rd(2, v);
        check(v == 32'h82 && req_cnt == 0, "R6 fetch src misaligned", v, 32'h82);
        wr(4, 32'h201); run(32'h200); rd(2, v);
        check(v == 32'h108 && req_cnt == 0, "R6 write dst misaligned", v, 32'h108);
        wr(4, 0); run(32'h400); rd(2, v);
        check(v == 32'h1A0 && req_cnt == 0, "R6 copy both bad", v, 32'h1A0);
        wr(3, 32'h100); run(32'h400); rd(2, v);
        check(v == 32'h120 && req_cnt == 0, "R6 copy dst bad", v, 32'h120);

        // R7 error responses
        wr(5, 16); wr(3, 32'h100); wr(4, 32'h200); wr(6, 32'h1234);
        err_addr = 32'h104;
        run(32'h100); rd(2, v);
        check(v == 32'h2 && req_cnt == 2, "R7 fetch error", v, 2);
        run(32'h400); rd(2, v);
        check(v == 32'h20 && req_cnt == 3, "R7 copy error", v, 32'h20);
        err_addr = 32'h204;
        run(32'h200); rd(2, v);
        check(v == 32'h8 && req_cnt == 2, "R7 write error", v, 8);
        rd(6, v); check(v == 32'h1234, "R7 checksum kept", v, 32'h1234);
        err_addr = 32'hFFFF_FFFF;

        // R8 interrupts
        run(32'h1); rd(2, v);
        check(v == 32'h40 && leg_cnt == 1 && msg_cnt == 0, "R8 legacy", v, 32'h40);
        for (int vec = 0; vec < 64; vec++) begin
            run(32'h2 | (32'(vec) << 2));
            check(msg_cnt == 1 && leg_cnt == 0 && seen_vec == 6'(vec), "R8 msg vector",
                  {26'd0, seen_vec}, vec);
        end
        s = 0;
        for (int i = 0; i < 4; i++) s += mem[64 + i];
        wr(6, s);
        run(32'h103 | (32'd45 << 2)); rd(2, v);
        check(v == 32'h41 && leg_cnt == 1 && msg_cnt == 1 && seen_vec == 6'd45,
              "R8 fetch with both irqs", v, 32'h41);

        // R9 command write during a long fetch
        for (int i = 0; i < 12; i++) mem[128 + i] = 32'hBEEF_0000 + i;
        s = 0;
        for (int i = 0; i < 10; i++) s += mem[64 + i];
        wr(5, 40); wr(6, s);
        leg_cnt = 0; msg_cnt = 0; req_cnt = 0;
        wr(1, 32'h100);
        wr(1, 32'h201);
        for (int t = 0; t < 200; t++) begin @(posedge clk); #1; rd(1, v); if (v == 0) break; end
        @(posedge clk); #1;
        rd(2, v); check(v == 32'h1 && leg_cnt == 0, "R9 busy write ignored", v, 1);
        check(mem[128] == 32'hBEEF_0000 && mem[137] == 32'hBEEF_0009, "R9 dst untouched",
              mem[128], 32'hBEEF_0000);

        // R10 priority
        run(32'h700); rd(2, v);
        check(v == 32'h1 && req_cnt == 10, "R10 fetch wins", v, 1);
        check(mem[128] == 32'hBEEF_0000, "R10 no write", mem[128], 32'hBEEF_0000);
        run(32'h600); rd(2, v);
        check(v == 32'h4 && mem[128] == pat(0), "R10 write over copy", v, 4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule